// File: doc/BRIEF.md
# Flag-Based I/O and Interrupt Controller

This block sits beside a small accumulator processor and handles its character I/O and its single interrupt. It owns an 8-bit input holding register, an 8-bit output holding register, one ready flag for each, an interrupt-enable bit and an interrupt-pending bit. The device side offers a byte with a strobe and acknowledges output bytes with a strobe. The CPU side presents the current timing step of its sequence counter, a decoded "this is an I/O instruction" line, six instruction bits, the low accumulator byte and the program counter.

I/O instructions run in timing step 3. Between instructions, when interrupts are enabled and either ready flag is up, the block latches a pending interrupt. It then replaces the next fetch with a three-step hardware call. That call saves the program counter at memory location 0 and resumes execution at location 1. The block does not hold the CPU's address register, program counter or sequence counter. It drives strobes that tell the CPU what to do with them in the current step.

Top module: `io_irq_ctrl`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, interrupt enable is 0, no interrupt is pending and the output register is 0.
- R2: A device input strobe while the input flag is 0 loads the byte and sets the flag at the next edge. A strobe while the flag is 1, with no INP in the same cycle, is ignored and the held byte is kept.
- R3: INP is instruction bit 11, on `ir_bits_i[5]`. In the cycle where it executes, `ac_lo_ld_o` is 1 and `ac_lo_o` carries the held input byte, and the input flag clears at the edge. If a device strobe arrives in that same cycle, the new byte is loaded and the flag stays 1.
- R4: OUT is bit 11-1=10, on `ir_bits_i[4]`. It copies `ac_lo_i` into the output register and clears the output flag at the edge. A device acknowledge sets the output flag, and an acknowledge in the same cycle as OUT leaves the flag at 1.
- R5: SKI is bit 9, on `ir_bits_i[3]`, and raises `pc_skip_o` in its execute cycle when the input flag is 1. SKO is bit 8, on `ir_bits_i[2]`, and does the same when the output flag is 1. Otherwise `pc_skip_o` is 0.
- R6: ION is bit 7, on `ir_bits_i[1]`, and sets interrupt enable. IOF is bit 6, on `ir_bits_i[0]`, and clears it. When both are given in one instruction, enable ends up 0.
- R7: An I/O instruction executes only when `io_sel_i` is 1 and `step_i` is 3, and it raises `sc_clr_o` in that cycle. At any other step, `io_sel_i` has no effect.
- R8: The interrupt-pending bit is set at an edge only when `step_i` is 3 or more, enable is 1 and either flag is 1. It is never set from steps 0, 1 or 2, and never while enable is 0.
- R9: While pending, step 0 raises `ar_clr_o` and `tr_ld_o` and captures `pc_i`. Step 1 raises `mem_wr_o` with `mem_wdata_o` equal to the captured PC, zero-extended, and raises `pc_clr_o`. Step 2 raises `pc_inc_o` and `sc_clr_o`, and at that edge both pending and enable clear.
- R10: `fetch_block_o` equals the pending bit, so normal fetch resumes in the step 0 after the interrupt cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 4 | Current timing step from the CPU sequence counter |
| io_sel_i | input | 1 | Decoded I/O-instruction class |
| ir_bits_i | input | 6 | Instruction bits 11 down to 6 |
| ac_lo_i | input | 8 | Low byte of the accumulator |
| pc_i | input | 12 | Current program counter |
| dev_in_stb_i | input | 1 | Device offers a new input byte |
| dev_in_data_i | input | 8 | Device input byte |
| dev_out_ack_i | input | 1 | Device consumed the output byte |
| ac_lo_ld_o | output | 1 | Load accumulator low byte from `ac_lo_o` |
| ac_lo_o | output | 8 | Held input byte |
| pc_skip_o | output | 1 | Increment PC to skip the next instruction |
| sc_clr_o | output | 1 | Clear the CPU sequence counter |
| fetch_block_o | output | 1 | Interrupt pending: suppress normal fetch |
| ar_clr_o | output | 1 | Clear the address register |
| tr_ld_o | output | 1 | Load temporary register from PC |
| mem_wr_o | output | 1 | Memory write of the saved PC |
| mem_wdata_o | output | 16 | Saved PC, zero-extended |
| pc_clr_o | output | 1 | Clear PC |
| pc_inc_o | output | 1 | Increment PC at end of interrupt cycle |
| dev_out_data_o | output | 8 | Output register to device |
| in_flag_o | output | 1 | Input ready flag |
| out_flag_o | output | 1 | Output ready flag |
| ien_o | output | 1 | Interrupt enable |

## Verification
Every CPU-side strobe (`ac_lo_ld_o`, `pc_skip_o`, `sc_clr_o`, the interrupt-cycle strobes) is combinational from the step and the held state, so it is due in the same cycle as the stimulus. Flags, registers, enable and the pending bit change at the clock edge that ends the stimulus cycle, so they are due one cycle later. The driver applies each stimulus at the falling edge and queues the expected items: strobes in the stimulus cycle, state in the following cycle. The monitor pops and compares the queued items shortly after that falling edge, once the combinational outputs have settled. The interrupt test steps through 0, 1 and 2 with enable on and a flag up, to confirm that no request is taken in those steps.

// File: rtl/io_irq_pkg.sv
package io_irq_pkg;

    // Positions inside the 6-bit I/O field (instruction bits 11..6)
    localparam int CMD_INP = 5;
    localparam int CMD_OUT = 4;
    localparam int CMD_SKI = 3;
    localparam int CMD_SKO = 2;
    localparam int CMD_ION = 1;
    localparam int CMD_IOF = 0;
    localparam int CMD_W   = 6;

    typedef struct packed {
        logic inp;
        logic out;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_cmd_t;

endpackage

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
    import io_irq_pkg::*;
#(
    parameter int STEP_W    = 4,
    parameter int EXEC_STEP = 3
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              io_sel_i,
    input  logic [CMD_W-1:0]  bits_i,
    output io_cmd_t           cmd_o,
    output logic              active_o
);
    localparam logic [STEP_W-1:0] ST_EXEC = STEP_W'(EXEC_STEP);

    logic active;

    always_comb begin
        active    = io_sel_i && (step_i == ST_EXEC);
        cmd_o     = '0;
        if (active) begin
            cmd_o.inp = bits_i[CMD_INP];
            cmd_o.out = bits_i[CMD_OUT];
            cmd_o.ski = bits_i[CMD_SKI];
            cmd_o.sko = bits_i[CMD_SKO];
            cmd_o.ion = bits_i[CMD_ION];
            cmd_o.iof = bits_i[CMD_IOF];
        end
        active_o = active;
    end
endmodule

// File: rtl/io_port_regs.sv
module io_port_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_inp_i,
    input  logic              do_out_i,
    input  logic              do_ski_i,
    input  logic              do_sko_i,
    input  logic [DATA_W-1:0] ac_lo_i,
    input  logic              dev_in_stb_i,
    input  logic [DATA_W-1:0] dev_in_data_i,
    input  logic              dev_out_ack_i,
    output logic              ac_lo_ld_o,
    output logic [DATA_W-1:0] ac_lo_o,
    output logic              skip_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              fgi_o,
    output logic              fgo_o
);
    typedef struct packed {
        logic [DATA_W-1:0] in_reg;
        logic [DATA_W-1:0] out_reg;
        logic              fgi;
        logic              fgo;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     in_accept;

    always_comb begin
        st_d      = st_q;
        // A pending byte is replaced only when the CPU reads it in this cycle
        in_accept = dev_in_stb_i && (!st_q.fgi || do_inp_i);

        if (in_accept) begin
            st_d.in_reg = dev_in_data_i;
        end
        if (in_accept) begin
            st_d.fgi = 1'b1;
        end else if (do_inp_i) begin
            st_d.fgi = 1'b0;
        end

        if (do_out_i) begin
            st_d.out_reg = ac_lo_i;
        end
        if (dev_out_ack_i) begin
            st_d.fgo = 1'b1;
        end else if (do_out_i) begin
            st_d.fgo = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{in_reg: '0, out_reg: '0, fgi: 1'b0, fgo: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_lo_ld_o = do_inp_i;
    assign ac_lo_o    = st_q.in_reg;
    assign skip_o     = (do_ski_i && st_q.fgi) || (do_sko_i && st_q.fgo);
    assign out_data_o = st_q.out_reg;
    assign fgi_o      = st_q.fgi;
    assign fgo_o      = st_q.fgo;

    // R2
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fgi && dev_in_stb_i && !do_inp_i) |=> $stable(st_q.in_reg));

    // R3
    inp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_inp_i && !dev_in_stb_i) |=> !st_q.fgi);

    // R4
    out_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_out_i |=> (st_q.out_reg == $past(ac_lo_i)));

    // R4
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_ack_i |=> st_q.fgo);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
    parameter int STEP_W = 4,
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  logic              do_ion_i,
    input  logic              do_iof_i,
    input  logic              fgi_i,
    input  logic              fgo_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              pend_o,
    output logic              ien_o,
    output logic              ar_clr_o,
    output logic              tr_ld_o,
    output logic              mem_wr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              pc_clr_o,
    output logic              pc_inc_o,
    output logic              sc_clr_o
);
    localparam logic [STEP_W-1:0] ST_SAVE = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_WR   = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_DONE = STEP_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] saved_pc;
        logic              ien;
        logic              pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    in_fetch_steps;
    logic    ph_save, ph_wr, ph_done;

    always_comb begin
        st_d           = st_q;
        in_fetch_steps = (step_i <= ST_DONE);
        ph_save        = st_q.pend && (step_i == ST_SAVE);
        ph_wr          = st_q.pend && (step_i == ST_WR);
        ph_done        = st_q.pend && (step_i == ST_DONE);

        if (do_iof_i) begin
            st_d.ien = 1'b0;
        end else if (do_ion_i) begin
            st_d.ien = 1'b1;
        end

        if (!st_q.pend && !in_fetch_steps && st_q.ien && (fgi_i || fgo_i)) begin
            st_d.pend = 1'b1;
        end

        if (ph_save) begin
            st_d.saved_pc = pc_i;
        end
        if (ph_done) begin
            st_d.pend = 1'b0;
            st_d.ien  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (WORD_W > ADDR_W) begin : g_pad
            assign mem_wdata_o = {{(WORD_W-ADDR_W){1'b0}}, st_q.saved_pc};
        end else begin : g_trunc
            assign mem_wdata_o = st_q.saved_pc[WORD_W-1:0];
        end
    endgenerate

    assign pend_o   = st_q.pend;
    assign ien_o    = st_q.ien;
    assign ar_clr_o = ph_save;
    assign tr_ld_o  = ph_save;
    assign mem_wr_o = ph_wr;
    assign pc_clr_o = ph_wr;
    assign pc_inc_o = ph_done;
    assign sc_clr_o = ph_done;

    // R8
    no_fetch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && (step_i <= ST_DONE)) |=> !st_q.pend);

    // R8
    req_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(st_q.ien));

    // R9
    irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && (step_i == ST_DONE)) |=> (!st_q.pend && !st_q.ien));

    // R9
    save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && (step_i == ST_SAVE)) |=> (st_q.saved_pc == $past(pc_i)));
endmodule

// File: rtl/io_irq_ctrl.sv
module io_irq_ctrl
    import io_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STEP_W    = 4,
    parameter int ADDR_W    = 12,
    parameter int WORD_W    = 16,
    parameter int EXEC_STEP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  logic              io_sel_i,
    input  logic [CMD_W-1:0]  ir_bits_i,
    input  logic [DATA_W-1:0] ac_lo_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              dev_in_stb_i,
    input  logic [DATA_W-1:0] dev_in_data_i,
    input  logic              dev_out_ack_i,
    output logic              ac_lo_ld_o,
    output logic [DATA_W-1:0] ac_lo_o,
    output logic              pc_skip_o,
    output logic              sc_clr_o,
    output logic              fetch_block_o,
    output logic              ar_clr_o,
    output logic              tr_ld_o,
    output logic              mem_wr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              pc_clr_o,
    output logic              pc_inc_o,
    output logic [DATA_W-1:0] dev_out_data_o,
    output logic              in_flag_o,
    output logic              out_flag_o,
    output logic              ien_o
);
    io_cmd_t cmd;
    logic    io_active;
    logic    fgi, fgo;
    logic    irq_sc_clr;

    io_cmd_decode #(
        .STEP_W    (STEP_W),
        .EXEC_STEP (EXEC_STEP)
    ) u_decode (
        .step_i   (step_i),
        .io_sel_i (io_sel_i),
        .bits_i   (ir_bits_i),
        .cmd_o    (cmd),
        .active_o (io_active)
    );

    io_port_regs #(
        .DATA_W (DATA_W)
    ) u_ports (
        .clk           (clk),
        .rst_n         (rst_n),
        .do_inp_i      (cmd.inp),
        .do_out_i      (cmd.out),
        .do_ski_i      (cmd.ski),
        .do_sko_i      (cmd.sko),
        .ac_lo_i       (ac_lo_i),
        .dev_in_stb_i  (dev_in_stb_i),
        .dev_in_data_i (dev_in_data_i),
        .dev_out_ack_i (dev_out_ack_i),
        .ac_lo_ld_o    (ac_lo_ld_o),
        .ac_lo_o       (ac_lo_o),
        .skip_o        (pc_skip_o),
        .out_data_o    (dev_out_data_o),
        .fgi_o         (fgi),
        .fgo_o         (fgo)
    );

    irq_sequencer #(
        .STEP_W (STEP_W),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .do_ion_i    (cmd.ion),
        .do_iof_i    (cmd.iof),
        .fgi_i       (fgi),
        .fgo_i       (fgo),
        .pc_i        (pc_i),
        .pend_o      (fetch_block_o),
        .ien_o       (ien_o),
        .ar_clr_o    (ar_clr_o),
        .tr_ld_o     (tr_ld_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .pc_clr_o    (pc_clr_o),
        .pc_inc_o    (pc_inc_o),
        .sc_clr_o    (irq_sc_clr)
    );

    assign sc_clr_o   = io_active || irq_sc_clr;
    assign in_flag_o  = fgi;
    assign out_flag_o = fgo;

    // R7
    io_step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel_i && (step_i != STEP_W'(EXEC_STEP)) && !fetch_block_o) |-> !ac_lo_ld_o && !pc_skip_o);
endmodule

// File: tb/io_irq_ctrl_tb_top.sv
module io_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] B_INP = 6'b100000;
    localparam logic [5:0] B_OUT = 6'b010000;
    localparam logic [5:0] B_SKI = 6'b001000;
    localparam logic [5:0] B_SKO = 6'b000100;
    localparam logic [5:0] B_ION = 6'b000010;
    localparam logic [5:0] B_IOF = 6'b000001;

    typedef enum int {
        S_ACLD, S_ACLO, S_SKIP, S_SCCLR, S_PEND, S_ARCLR, S_TRLD, S_MEMWR,
        S_MEMD, S_PCCLR, S_PCINC, S_OUTD, S_FGI, S_FGO, S_IEN
    } sig_e;

    typedef struct {
        sig_e        sig;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  step = '0;
    logic        sel = 1'b0;
    logic [5:0]  bits = '0;
    logic [7:0]  ac = '0;
    logic [11:0] pc = '0;
    logic        stb = 1'b0;
    logic [7:0]  din = '0;
    logic        ack = 1'b0;

    logic        ac_lo_ld, pc_skip, sc_clr, fetch_block, ar_clr, tr_ld;
    logic        mem_wr, pc_clr, pc_inc, in_flag, out_flag, ien;
    logic [7:0]  ac_lo, dev_out;
    logic [15:0] mem_wdata;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    io_irq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .step_i (step), .io_sel_i (sel),
        .ir_bits_i (bits), .ac_lo_i (ac), .pc_i (pc),
        .dev_in_stb_i (stb), .dev_in_data_i (din), .dev_out_ack_i (ack),
        .ac_lo_ld_o (ac_lo_ld), .ac_lo_o (ac_lo), .pc_skip_o (pc_skip),
        .sc_clr_o (sc_clr), .fetch_block_o (fetch_block), .ar_clr_o (ar_clr),
        .tr_ld_o (tr_ld), .mem_wr_o (mem_wr), .mem_wdata_o (mem_wdata),
        .pc_clr_o (pc_clr), .pc_inc_o (pc_inc), .dev_out_data_o (dev_out),
        .in_flag_o (in_flag), .out_flag_o (out_flag), .ien_o (ien)
    );

    function automatic logic [15:0] read_sig(sig_e s);
        case (s)
            S_ACLD:  return {15'd0, ac_lo_ld};
            S_ACLO:  return {8'd0, ac_lo};
            S_SKIP:  return {15'd0, pc_skip};
            S_SCCLR: return {15'd0, sc_clr};
            S_PEND:  return {15'd0, fetch_block};
            S_ARCLR: return {15'd0, ar_clr};
            S_TRLD:  return {15'd0, tr_ld};
            S_MEMWR: return {15'd0, mem_wr};
            S_MEMD:  return mem_wdata;
            S_PCCLR: return {15'd0, pc_clr};
            S_PCINC: return {15'd0, pc_inc};
            S_OUTD:  return {8'd0, dev_out};
            S_FGI:   return {15'd0, in_flag};
            S_FGO:   return {15'd0, out_flag};
            default: return {15'd0, ien};
        endcase
    endfunction

    // Driver: one CPU/device cycle applied at the falling edge
    task automatic cyc(input logic [3:0] st, input logic s, input logic [5:0] b,
                       input logic [7:0] a, input logic [11:0] p,
                       input logic is, input logic [7:0] d, input logic k);
        @(negedge clk);
        step = st; sel = s; bits = b; ac = a; pc = p; stb = is; din = d; ack = k;
    endtask

    task automatic ex(input sig_e s, input logic [15:0] v, input string r);
        item_t it;
        it.sig = s; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    // Monitor: compares queued expectations once outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = read_sig(it.sig);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", it.req, it.sig.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        ex(S_FGI, 0, "R1"); ex(S_FGO, 1, "R1"); ex(S_IEN, 0, "R1");
        ex(S_PEND, 0, "R1"); ex(S_OUTD, 0, "R1");
        // R2 input byte arrives
        cyc(4, 0, 0, 0, 0, 1, 8'h5A, 0);
        ex(S_FGI, 0, "R2");
        cyc(5, 0, 0, 0, 0, 1, 8'h33, 0);    // second strobe, must be dropped
        ex(S_FGI, 1, "R2");
        // R3 INP reads the first byte
        cyc(3, 1, B_INP, 0, 0, 0, 0, 0);
        ex(S_ACLD, 1, "R3"); ex(S_ACLO, 16'h5A, "R2"); ex(S_SCCLR, 1, "R7");
        // R7 I/O select outside step 3
        cyc(5, 1, B_INP, 0, 0, 0, 0, 0);
        ex(S_FGI, 0, "R3"); ex(S_ACLD, 0, "R7"); ex(S_SCCLR, 0, "R7");
        cyc(3, 1, B_SKI, 0, 0, 0, 0, 0);
        ex(S_FGI, 0, "R7"); ex(S_SKIP, 0, "R5");
        cyc(3, 1, B_SKO, 0, 0, 0, 0, 0);
        ex(S_SKIP, 1, "R5");
        // R4 OUT
        cyc(3, 1, B_OUT, 8'hC3, 0, 0, 0, 0);
        ex(S_OUTD, 0, "R4"); ex(S_FGO, 1, "R4");
        cyc(3, 1, B_SKO, 0, 0, 0, 0, 0);
        ex(S_OUTD, 16'hC3, "R4"); ex(S_FGO, 0, "R4"); ex(S_SKIP, 0, "R5");
        cyc(6, 0, 0, 0, 0, 0, 0, 1);
        ex(S_FGO, 0, "R4");
        cyc(3, 1, B_OUT, 8'h11, 0, 0, 0, 1); // OUT and ack together
        ex(S_FGO, 1, "R4");
        cyc(4, 0, 0, 0, 0, 1, 8'h77, 0);
        ex(S_OUTD, 16'h11, "R4"); ex(S_FGO, 1, "R4");
        cyc(3, 1, B_SKI, 0, 0, 0, 0, 0);
        ex(S_FGI, 1, "R2"); ex(S_SKIP, 1, "R5");
        // R3 INP with a strobe in the same cycle
        cyc(3, 1, B_INP, 0, 0, 1, 8'h99, 0);
        ex(S_ACLO, 16'h77, "R3"); ex(S_ACLD, 1, "R3");
        cyc(3, 1, B_INP, 0, 0, 0, 0, 0);
        ex(S_FGI, 1, "R3"); ex(S_ACLO, 16'h99, "R3");
        cyc(4, 0, 0, 0, 0, 0, 0, 0);
        ex(S_FGI, 0, "R3"); ex(S_PEND, 0, "R8");
        cyc(7, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8");
        // R6 enable control
        cyc(3, 1, B_ION | B_IOF, 0, 0, 0, 0, 0);
        ex(S_IEN, 0, "R6");
        cyc(3, 1, B_ION, 0, 0, 0, 0, 0);
        ex(S_IEN, 0, "R6");
        // R8 no request from steps 0..2 (output flag is up)
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        ex(S_IEN, 1, "R6"); ex(S_PEND, 0, "R8");
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8");
        cyc(2, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8"); ex(S_ARCLR, 0, "R10");
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8");
        cyc(4, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 1, "R8"); ex(S_ARCLR, 0, "R9"); ex(S_MEMWR, 0, "R9");
        // R9 interrupt cycle
        cyc(0, 0, 0, 0, 12'h123, 0, 0, 0);
        ex(S_ARCLR, 1, "R9"); ex(S_TRLD, 1, "R9"); ex(S_MEMWR, 0, "R9");
        ex(S_PEND, 1, "R10"); ex(S_SCCLR, 0, "R9");
        cyc(1, 0, 0, 0, 12'h124, 0, 0, 0);
        ex(S_MEMWR, 1, "R9"); ex(S_MEMD, 16'h0123, "R9"); ex(S_PCCLR, 1, "R9");
        ex(S_ARCLR, 0, "R9");
        cyc(2, 0, 0, 0, 12'h000, 0, 0, 0);
        ex(S_PCINC, 1, "R9"); ex(S_SCCLR, 1, "R9"); ex(S_MEMWR, 0, "R9");
        ex(S_IEN, 1, "R9");
        cyc(0, 0, 0, 0, 12'h001, 0, 0, 0);
        ex(S_PEND, 0, "R10"); ex(S_IEN, 0, "R9"); ex(S_ARCLR, 0, "R10");
        ex(S_TRLD, 0, "R10");
        // R6 IOF alone; R8 no request with flags down or enable off
        cyc(3, 1, B_OUT, 8'h42, 0, 0, 0, 0);
        ex(S_FGO, 1, "R4");
        cyc(3, 1, B_ION, 0, 0, 0, 0, 0);
        ex(S_FGO, 0, "R4"); ex(S_OUTD, 16'h42, "R4");
        cyc(4, 0, 0, 0, 0, 0, 0, 0);
        ex(S_IEN, 1, "R6");
        cyc(3, 1, B_IOF, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8");
        cyc(5, 0, 0, 0, 0, 0, 0, 1);
        ex(S_IEN, 0, "R6");
        cyc(6, 0, 0, 0, 0, 0, 0, 0);
        ex(S_FGO, 1, "R4"); ex(S_PEND, 0, "R8");
        cyc(7, 0, 0, 0, 0, 0, 0, 0);
        ex(S_PEND, 0, "R8");

        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule